// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver with Hardware Flow Control

The block is a full-duplex asynchronous serial port. A host pushes characters into a four-entry transmit queue. The transmitter serializes each character onto `txd` as a low start bit, then the data bits with the least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between characters, and a gap between characters may last any length of time. The receiver watches `rxd` for a falling edge. It oversamples the line sixteen times per bit and rebuilds the character. It then places the character, together with a parity-error flag and a framing-error flag, into a four-entry receive queue. The host reads that queue from its head, and the head is always visible without a read.

The character format is set by four static configuration inputs: seven or eight data bits, parity on or off, odd or even parity, and one or two stop bits. A frame therefore lasts 9 to 12 bit times. The bit rate is set from outside by `baud_tick`, which pulses once per sixteenth of a bit. Both directions are throttled by active-low handshake lines. The transmitter will not begin a character while `cts_n` is high. The block raises `rts_n` once its receive queue is close to full.

Top module: `sfc_uart`

## Requirements
- R1: After reset, `txd` and `rts_n` are at their idle levels (`txd`=1, `rts_n`=0), `rx_empty`=1, `tx_full`=0 and `overrun`=0. `txd` stays high whenever the transmitter is not busy.
- R2: A transmitted frame holds each bit for exactly 16 `baud_tick` pulses. The bits are sent in this order: start (0), data bits least significant first, parity when enabled, then stop bits (1).
- R3: The frame length is 1 + D + P + S bit times. D is 7 when `cfg_data7`=1 and 8 otherwise. P is 1 when `cfg_par_en`=1. S is 2 when `cfg_stop2`=1 and 1 otherwise. When a second character is queued, its start bit follows the last stop bit with no gap.
- R4: The parity bit is the XOR of the transmitted data bits when `cfg_par_odd`=0 (even), and the inverse of that XOR when `cfg_par_odd`=1 (odd).
- R5: A new character is never started while `cts_n`=1. A character already under way is completed in full.
- R6: The transmit queue holds 4 characters and `tx_full` is 1 when it does. A write while `tx_full`=1 is discarded.
- R7: A received frame in any configuration yields its data on `rd_data`. In 7-bit mode, `rd_data[7]`=0.
- R8: `rd_par_err` is 1 for a received character whose parity bit disagrees with the configured parity. It is 0 otherwise.
- R9: `rd_frm_err` is 1 when the first stop bit is sampled low.
- R10: The receive queue holds 4 characters in arrival order. The oldest one is shown on `rd_data` while `rx_empty`=0, and a pulse on `rd_en` removes it.
- R11: `rts_n` is 1 while the receive queue holds 3 or more characters and 0 while it holds fewer. It follows the queue level one clock later.
- R12: A character that completes while the receive queue is full is dropped and `overrun` is set. `overrun` stays set until a `stat_rd` pulse clears it.
- R13: A low pulse on `rxd` shorter than half a bit is rejected as noise and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | Oversampling enable, one pulse per 1/16 bit |
| cfg_data7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Character to transmit |
| tx_full | output | 1 | Transmit queue full |
| rd_en | input | 1 | Remove the head of the receive queue |
| rd_data | output | 8 | Head character of the receive queue |
| rd_par_err | output | 1 | Parity error of the head character |
| rd_frm_err | output | 1 | Framing error of the head character |
| rx_empty | output | 1 | Receive queue empty |
| stat_rd | input | 1 | Status read strobe; clears `overrun` |
| overrun | output | 1 | Sticky flag: a character was dropped |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Active-low clear-to-send from the remote side |
| rxd | input | 1 | Serial receive line |
| rts_n | output | 1 | Active-low request-to-send to the remote side |
| tx_busy | output | 1 | Transmitter is sending a frame |

## Verification
A queued character reaches `txd` two clocks after it is written: one clock to enter the queue and one to load the shifter. From then on, with `baud_tick` held high, every bit lasts exactly 16 clocks. The bench therefore waits for the first low sample of `txd` and compares every later clock against the bit it predicts for that clock. This makes bit order and frame length exact to the cycle. On the receive side, `rxd` passes a two-stage synchronizer, so a character appears at the queue head a little after the middle of its first stop bit. The bench keeps `rxd` idle for 20 clocks after each frame before it reads the head. `rts_n` follows the queue level one clock later, and `overrun` rises the clock after the dropped character's stop sample. The bench samples both after waiting at least two clocks. All sampling happens on the falling clock edge.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // Phases shared by the serializer and the deserializer.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP1,
    PH_STOP2
  } phase_e;

  // One receive queue entry: error flags travel with their character.
  typedef struct packed {
    logic       par_err;
    logic       frm_err;
    logic [7:0] data;
  } rx_word_t;

  localparam int unsigned RX_WORD_W = $bits(rx_word_t);

endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0]    level_q, level_d;
  logic             do_push, do_pop;

  assign do_push = push && (level_q != LW'(DEPTH));
  assign do_pop  = pop  && (level_q != '0);

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    level_d = level_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop)      level_d = level_q + 1'b1;
    else if (do_pop && !do_push) level_d = level_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      level_q <= level_d;
    end
  end

  // Storage carries no reset; only the pointers do.
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= push_data;
  end

  assign head  = mem_q[rptr_q];
  assign level = level_q;

endmodule

// File: rtl/sfc_tx.sv
module sfc_tx
  import sfc_pkg::*;
#(
  parameter int unsigned OSR = 16,
  localparam int unsigned CW = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       data7,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic       cts_n,
  input  logic       q_empty,
  input  logic [7:0] q_head,
  output logic       q_pop,
  output logic       txd,
  output logic       busy
);

  phase_e      phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]  idx_q, idx_d;
  logic [7:0]  sh_q, sh_d;
  logic        par_q, par_d;
  logic        txd_q, txd_d;
  logic        bit_end, frame_end, load;
  logic [2:0]  last_idx;
  logic [7:0]  mask;

  assign last_idx  = data7 ? 3'd6 : 3'd7;
  assign mask      = data7 ? 8'h7F : 8'hFF;
  assign bit_end   = tick && (cnt_q == CW'(OSR - 1));
  assign frame_end = bit_end && (((phase_q == PH_STOP1) && !stop2) || (phase_q == PH_STOP2));
  // R5: a new character starts only while cts_n is low; R3: back-to-back on frame end
  assign load      = ((phase_q == PH_IDLE) || frame_end) && !q_empty && !cts_n;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    par_d   = par_q;
    txd_d   = txd_q;
    if (load) begin
      phase_d = PH_START;
      cnt_d   = '0;
      sh_d    = q_head;
      par_d   = par_odd ^ (^(q_head & mask));   // R4
      txd_d   = 1'b0;
    end else if ((phase_q != PH_IDLE) && tick) begin
      if (cnt_q != CW'(OSR - 1)) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        case (phase_q)
          PH_START: begin
            phase_d = PH_DATA;
            idx_d   = '0;
            txd_d   = sh_q[0];
          end
          PH_DATA: begin
            if (idx_q == last_idx) begin
              phase_d = par_en ? PH_PARITY : PH_STOP1;
              txd_d   = par_en ? par_q : 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
              sh_d  = sh_q >> 1;
              txd_d = sh_q[1];
            end
          end
          PH_PARITY: begin
            phase_d = PH_STOP1;
            txd_d   = 1'b1;
          end
          PH_STOP1: begin
            phase_d = stop2 ? PH_STOP2 : PH_IDLE;
            txd_d   = 1'b1;
          end
          default: begin
            phase_d = PH_IDLE;
            txd_d   = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      txd_q   <= txd_d;
    end
  end

  assign q_pop = load;
  assign txd   = txd_q;
  assign busy  = (phase_q != PH_IDLE);

endmodule

// File: rtl/sfc_rx.sv
module sfc_rx
  import sfc_pkg::*;
#(
  parameter int unsigned OSR = 16,
  localparam int unsigned CW = $clog2(OSR),
  localparam int unsigned HALF = OSR / 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     data7,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     rxd,
  output logic     push,
  output rx_word_t word
);

  logic [2:0]    sync_q;      // [0],[1] synchronizer, [2] previous synced value
  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    idx_q, idx_d;
  logic [7:0]    data_q, data_d;
  logic          acc_q, acc_d;
  logic          perr_q, perr_d;
  logic          line, fall, centre;
  logic [2:0]    last_idx;

  assign line     = sync_q[1];
  assign fall     = sync_q[2] && !sync_q[1];
  assign centre   = tick && (cnt_q == CW'(OSR - 1));
  assign last_idx = data7 ? 3'd6 : 3'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[1], sync_q[0], rxd};
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    data_d  = data_q;
    acc_d   = acc_q;
    perr_d  = perr_q;
    if (phase_q == PH_IDLE) begin
      if (fall) begin
        phase_d = PH_START;
        cnt_d   = '0;
        data_d  = '0;       // R7: unused top bit reads 0
        acc_d   = 1'b0;
        perr_d  = 1'b0;
      end
    end else if (phase_q == PH_START) begin
      if (tick) begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_d   = '0;
          idx_d   = '0;
          phase_d = line ? PH_IDLE : PH_DATA;   // R13: reject short pulse
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (tick) begin
      if (!centre) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        case (phase_q)
          PH_DATA: begin
            data_d[idx_q] = line;
            acc_d         = acc_q ^ line;
            if (idx_q == last_idx) phase_d = par_en ? PH_PARITY : PH_STOP1;
            else                   idx_d   = idx_q + 1'b1;
          end
          PH_PARITY: begin
            perr_d  = line ^ acc_q ^ par_odd;   // R8
            phase_d = PH_STOP1;
          end
          default: phase_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      acc_q   <= acc_d;
      perr_q  <= perr_d;
    end
  end

  // Character completes at the centre of the first stop bit (R9).
  assign push         = (phase_q == PH_STOP1) && centre;
  assign word.par_err = perr_q;
  assign word.frm_err = !line;
  assign word.data    = data_q;

endmodule

// File: rtl/sfc_uart.sv
module sfc_uart
  import sfc_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned RTS_LEVEL  = FIFO_DEPTH - 1,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       cfg_data7,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       tx_full,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_par_err,
  output logic       rd_frm_err,
  output logic       rx_empty,
  input  logic       stat_rd,
  output logic       overrun,
  output logic       txd,
  input  logic       cts_n,
  input  logic       rxd,
  output logic       rts_n,
  output logic       tx_busy
);

  logic [1:0]       rsync_q;
  logic             rst_core_n;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic [7:0]       tx_head;
  logic             tx_pop, rx_push, rx_full;
  rx_word_t         rx_word, rx_head;
  logic             ovr_q, ovr_d, rts_q, rts_d;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  sfc_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_core_n),
    .push(wr_en), .push_data(wr_data),
    .pop(tx_pop), .head(tx_head), .level(tx_level)
  );

  sfc_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .tick(baud_tick),
    .data7(cfg_data7), .par_en(cfg_par_en), .par_odd(cfg_par_odd), .stop2(cfg_stop2),
    .cts_n(cts_n), .q_empty(tx_level == '0), .q_head(tx_head),
    .q_pop(tx_pop), .txd(txd), .busy(tx_busy)
  );

  sfc_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .tick(baud_tick),
    .data7(cfg_data7), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .rxd(rxd), .push(rx_push), .word(rx_word)
  );

  sfc_fifo #(.WIDTH(RX_WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_core_n),
    .push(rx_push), .push_data(rx_word),
    .pop(rd_en), .head(rx_head), .level(rx_level)
  );

  assign rx_full = (rx_level == LVL_W'(FIFO_DEPTH));

  // R12: set on a dropped character, cleared by a status read; set wins.
  assign ovr_d = (ovr_q && !stat_rd) || (rx_push && rx_full);
  // R11: throttle the remote sender near full.
  assign rts_d = (rx_level >= LVL_W'(RTS_LEVEL));

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ovr_q <= 1'b0;
      rts_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      rts_q <= rts_d;
    end
  end

  assign tx_full    = (tx_level == LVL_W'(FIFO_DEPTH));
  assign rx_empty   = (rx_level == '0);
  assign rd_data    = rx_head.data;
  assign rd_par_err = rx_head.par_err;
  assign rd_frm_err = rx_head.frm_err;
  assign overrun    = ovr_q;
  assign rts_n      = rts_q;

endmodule

// File: rtl/sfc_uart_chk.sv
module sfc_uart_chk #(
  parameter int unsigned LW     = 3,
  parameter int unsigned RTS_AT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cts_n,
  input logic          tx_pop,
  input logic          wr_en,
  input logic          tx_full,
  input logic          txd,
  input logic          tx_busy,
  input logic [LW-1:0] rx_level,
  input logic          rx_push,
  input logic          rts_n,
  input logic          overrun,
  input logic          stat_rd
);

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  p_cts_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !cts_n);

  p_full_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_full && !tx_pop) |=> tx_full);

  p_rts_raise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= LW'(RTS_AT)) |=> rts_n);

  p_rts_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level < LW'(RTS_AT)) |=> !rts_n);

  p_overrun_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && (rx_level == LW'(RTS_AT + 1))) |=> overrun);

  p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_rd) |=> overrun);

endmodule

bind sfc_uart sfc_uart_chk #(.LW(LVL_W), .RTS_AT(RTS_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .tx_pop(tx_pop),
  .wr_en(wr_en), .tx_full(tx_full), .txd(txd), .tx_busy(tx_busy),
  .rx_level(rx_level), .rx_push(rx_push), .rts_n(rts_n),
  .overrun(overrun), .stat_rd(stat_rd)
);

// File: tb/sfc_uart_bench.sv
module sfc_uart_bench;

  logic       clk, rst_n, baud_tick;
  logic       cfg_data7, cfg_par_en, cfg_par_odd, cfg_stop2;
  logic       wr_en, rd_en, stat_rd, cts_n, rxd;
  logic [7:0] wr_data;
  logic       tx_full, rd_par_err, rd_frm_err, rx_empty, overrun, txd, rts_n, tx_busy;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sfc_uart u_sfc_uart (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_data7(cfg_data7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .wr_en(wr_en), .wr_data(wr_data), .tx_full(tx_full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_par_err(rd_par_err), .rd_frm_err(rd_frm_err),
    .rx_empty(rx_empty), .stat_rd(stat_rd), .overrun(overrun), .txd(txd),
    .cts_n(cts_n), .rxd(rxd), .rts_n(rts_n), .tx_busy(tx_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int frame_len(input bit d7, input bit pe, input bit s2);
    return 1 + (d7 ? 7 : 8) + (pe ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  // Expected line level for bit position j of a frame.
  function automatic logic frame_bit(input logic [7:0] d, input int j,
                                     input bit d7, input bit pe, input bit po);
    int n = d7 ? 7 : 8;
    logic [7:0] m = d7 ? 8'h7F : 8'hFF;
    if (j == 0) return 1'b0;
    if (j <= n) return d[j-1];
    if (pe && (j == n + 1)) return po ^ (^(d & m));
    return 1'b1;
  endfunction

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Two back-to-back characters, checked on every clock.
  task automatic tx_pair(input logic [7:0] a, input logic [7:0] b, input int k);
    int L = frame_len(cfg_data7, cfg_par_en, cfg_stop2);
    int n = 0;
    int mism = 0;
    logic e;
    wr(a);
    wr(b);
    while (txd !== 1'b0 && n < 50) begin @(negedge clk); n++; end
    for (int c = 0; c < 2 * L * 16; c++) begin
      if (c < L * 16) e = frame_bit(a, c / 16, cfg_data7, cfg_par_en, cfg_par_odd);
      else            e = frame_bit(b, (c - L * 16) / 16, cfg_data7, cfg_par_en, cfg_par_odd);
      if (txd !== e) mism++;
      @(negedge clk);
    end
    chk(mism == 0 && n < 50, $sformatf("R2 R3 R4 tx frame cfg %0d mismatching clocks", k), mism, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int L = frame_len(cfg_data7, cfg_par_en, cfg_stop2);
    int n = cfg_data7 ? 7 : 8;
    logic b;
    for (int j = 0; j < L; j++) begin
      b = frame_bit(d, j, cfg_data7, cfg_par_en, cfg_par_odd);
      if (bad_par && cfg_par_en && j == n + 1) b = ~b;
      if (bad_stop && j == n + 1 + (cfg_par_en ? 1 : 0)) b = 1'b0;
      rxd = b;
      repeat (16) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic capture_tx(output logic [7:0] d, output bit ok);
    int n = 0;
    ok = 1'b1;
    d  = '0;
    while (txd !== 1'b0 && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) ok = 1'b0;
    repeat (8) @(negedge clk);
    if (txd !== 1'b0) ok = 1'b0;
    for (int j = 0; j < 8; j++) begin
      repeat (16) @(negedge clk);
      d[j] = txd;
    end
    repeat (16) @(negedge clk);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic set_cfg(input int k);
    int pm = (k / 2) % 3;
    cfg_data7   = k[0];
    cfg_par_en  = (pm != 0);
    cfg_par_odd = (pm == 2);
    cfg_stop2   = (k >= 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, v [5];
    logic [7:0] exp8;
    bit ok, high;
    rst_n = 1'b0; baud_tick = 1'b1;
    cfg_data7 = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; stat_rd = 1'b0; cts_n = 1'b0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: idle levels after reset
    chk(txd === 1'b1 && rts_n === 1'b0, "R1 txd/rts_n after reset", {txd, rts_n}, 2'b10);
    chk(rx_empty === 1'b1 && tx_full === 1'b0 && overrun === 1'b0,
        "R1 queue flags after reset", {rx_empty, tx_full, overrun}, 3'b100);

    // R2 R3 R4: every format, transmit side
    for (int k = 0; k < 12; k++) begin
      set_cfg(k);
      tx_pair(8'(8'h35 + k * 37), 8'(~(8'h35 + k * 37)), k);
    end

    // R7: every format, receive side
    for (int k = 0; k < 12; k++) begin
      set_cfg(k);
      exp8 = 8'(8'hA6 ^ (k * 19));
      rx_send(exp8, 1'b0, 1'b0);
      if (cfg_data7) exp8[7] = 1'b0;
      chk(rx_empty === 1'b0 && rd_data === exp8 && rd_par_err === 1'b0 && rd_frm_err === 1'b0,
          $sformatf("R7 rx data cfg %0d", k), {rx_empty, rd_par_err, rd_frm_err, rd_data},
          {3'b000, exp8});
      pop();
      chk(rx_empty === 1'b1, "R10 queue empty after read", rx_empty, 1);
    end

    // R8: corrupted parity, 8 data bits, even parity
    set_cfg(2);
    rx_send(8'h5B, 1'b1, 1'b0);
    chk(rd_par_err === 1'b1 && rd_frm_err === 1'b0 && rd_data === 8'h5B,
        "R8 parity error flag", {rd_par_err, rd_frm_err, rd_data}, {2'b10, 8'h5B});
    pop();
    // R9: low first stop bit
    rx_send(8'hC4, 1'b0, 1'b1);
    chk(rd_frm_err === 1'b1 && rd_par_err === 1'b0 && rd_data === 8'hC4,
        "R9 framing error flag", {rd_frm_err, rd_par_err, rd_data}, {2'b10, 8'hC4});
    pop();

    // R13: short low pulse on rxd
    set_cfg(0);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (60) @(negedge clk);
    chk(rx_empty === 1'b1, "R13 glitch produced no character", rx_empty, 1);

    // R5: blocked start, then in-progress completion
    cts_n = 1'b1;
    wr(8'h96);
    high = 1'b1;
    for (int c = 0; c < 100; c++) begin
      if (txd !== 1'b1) high = 1'b0;
      @(negedge clk);
    end
    chk(high, "R5 no start while cts_n high", high, 1);
    cts_n = 1'b0;
    capture_tx(got, ok);
    chk(ok && got === 8'h96, "R5 held character sent after cts_n low", got, 8'h96);
    repeat (10) @(negedge clk);
    wr(8'h3C);
    wr(8'hE1);
    fork
      capture_tx(got, ok);
      begin repeat (60) @(negedge clk); cts_n = 1'b1; end
    join
    chk(ok && got === 8'h3C, "R5 frame under way completes", got, 8'h3C);
    high = 1'b1;
    for (int c = 0; c < 100; c++) begin
      if (txd !== 1'b1) high = 1'b0;
      @(negedge clk);
    end
    chk(high, "R5 next character held back", high, 1);
    cts_n = 1'b0;
    capture_tx(got, ok);
    chk(ok && got === 8'hE1, "R5 second character after release", got, 8'hE1);
    repeat (10) @(negedge clk);

    // R6: transmit queue depth and dropped write
    cts_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      v[i] = 8'(8'h11 * (i + 1) + 8'h02);
      wr(v[i]);
    end
    chk(tx_full === 1'b1, "R6 tx_full after four writes", tx_full, 1);
    cts_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      capture_tx(got, ok);
      chk(ok && got === v[i], $sformatf("R6 queued character %0d", i), got, v[i]);
    end
    high = 1'b1;
    for (int c = 0; c < 200; c++) begin
      if (txd !== 1'b1) high = 1'b0;
      @(negedge clk);
    end
    chk(high, "R6 fifth write was discarded", high, 1);

    // R10 R11 R12: fill the receive queue and overflow it
    for (int i = 0; i < 5; i++) v[i] = 8'(8'h4D + i * 23);
    rx_send(v[0], 1'b0, 1'b0);
    rx_send(v[1], 1'b0, 1'b0);
    chk(rts_n === 1'b0, "R11 rts_n low at two entries", rts_n, 0);
    rx_send(v[2], 1'b0, 1'b0);
    chk(rts_n === 1'b1, "R11 rts_n high at three entries", rts_n, 1);
    rx_send(v[3], 1'b0, 1'b0);
    chk(overrun === 1'b0, "R12 no overrun while space remained", overrun, 0);
    rx_send(v[4], 1'b0, 1'b0);
    chk(overrun === 1'b1, "R12 overrun on fifth character", overrun, 1);
    for (int i = 0; i < 4; i++) begin
      chk(rx_empty === 1'b0 && rd_data === v[i], $sformatf("R10 order entry %0d", i), rd_data, v[i]);
      pop();
      @(negedge clk);
      if (i == 0) chk(rts_n === 1'b1, "R11 rts_n high at three after read", rts_n, 1);
      if (i == 1) chk(rts_n === 1'b0, "R11 rts_n low at two after read", rts_n, 0);
    end
    chk(rx_empty === 1'b1, "R12 dropped character absent", rx_empty, 1);
    chk(overrun === 1'b1, "R12 overrun sticky", overrun, 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
    chk(overrun === 1'b0, "R12 overrun cleared by status read", overrun, 0);
    chk(txd === 1'b1, "R1 line idle at end", txd, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule